// File: doc/BRIEF.md
# PHY Timing Mode and DLL Configurator

This block sets up an SD/eMMC I/O PHY for a new bus timing mode and card clock. On a start strobe it latches the requested timing mode, the clock selector, the drive strength and the enhanced-strobe flag. It then issues a fixed series of byte-wide register transfers on a simple request/acknowledge port.

The series programs the following, in order:
- the PHY mode word;
- for the HS200 and HS400 modes only, a read-modify-write of the pad control register that adds the drive strength;
- the output and input tap delays;
- the DLL trim;
- a DLL reset, followed by a DLL enable that carries a frequency field;
- repeated reads of the DLL status register until the lock bit is set.

Legacy timing leaves out the trim write, the DLL enable and the lock wait.

The block records the clock selector of the last accepted run. A later start with the same selector finishes at once and issues no transfers. A lock wait that lasts too long ends the run with an error. The registers already written are left as they are.

Top module: `phycfg_ctrl`

## Requirements
- R1: After reset, `done_o`, `err_o` and `phy_req_o` are low.
- R2: The first start after reset always runs the full series. A start whose `freq_sel_i` equals the selector of the last accepted run raises `done_o` in the next cycle, with `err_o` low and no transfer issued.
- R3: The first transfer of a run writes the mode word to address 0x11. The mode word is 0x01 when `strobe_en_i` is set, whatever `mode_i` holds. Otherwise it is 0x02 for HS400, 0x04 for legacy, 0x08 for DDR50, and 0x00 for high speed and HS200. The `mode_i` codes are 0 legacy, 1 high speed, 2 HS200, 3 DDR50 and 4 HS400; codes 5 to 7 act as legacy.
- R4: In HS200 and HS400 with strobe off, the mode write is followed by a read of address 0x01. The value read, ORed with `drv_i` shifted left by 2, is then written back to 0x01.
- R5: The block writes the output tap to 0x0D and then the input tap to 0x0C, each as (tap << 1) | 1. The taps are (output/input): high speed 3/2, DDR50 1/0, HS400 1/0xA and strobe 1/0. HS200 uses output tap 2 and writes 0x00 to 0x0C. Legacy writes 0x00 to both registers.
- R6: Outside legacy, the tap writes are followed by a write of `DLL_TRIM` (default 0x08) to 0x12. Legacy issues no write to 0x12.
- R7: The block next writes 0x00 to 0x00. Outside legacy, it then writes (code << 5) | 0x08 to 0x00 and reads 0x00 until a read returns bit 4 set; `done_o` follows with `err_o` low. In legacy, `done_o` follows the zero write and no read of 0x00 is issued.
- R8: The frequency code used in R7 comes from `freq_sel_i`: 0 (200 MHz) gives 0, 1 (100 MHz) gives 2, 2 (50 MHz) gives 1, and 3 (any other clock) gives 0.
- R9: Suppose a lock read completes with bit 4 clear after `LOCK_TIMEOUT` or more cycles of waiting. Then `done_o` and `err_o` rise together in the next cycle, and no further transfer is issued.
- R10: A start while a run is busy is ignored. It changes neither the running series nor the recorded clock selector.
- R11: Only one transfer is outstanding at a time. While `phy_req_o` is high and `phy_ack_i` is low, `phy_we_o`, `phy_addr_o` and `phy_wdata_o` stay stable. `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled only when idle |
| mode_i | input | 3 | Timing mode code |
| strobe_en_i | input | 1 | Enhanced-strobe request, overrides mode_i |
| freq_sel_i | input | 2 | Card clock selector |
| drv_i | input | 2 | Drive strength for the pad register |
| done_o | output | 1 | Run finished (one-cycle pulse) |
| err_o | output | 1 | Run ended on lock timeout, valid with done_o |
| phy_req_o | output | 1 | Register transfer request |
| phy_we_o | output | 1 | 1 = write, 0 = read |
| phy_addr_o | output | 8 | Register address |
| phy_wdata_o | output | 8 | Write data |
| phy_ack_i | input | 1 | Transfer acknowledge |
| phy_rdata_i | input | 8 | Read data, valid with phy_ack_i |

## Verification
Several rules are checked by assertions on every cycle:
- the port holds its request stable until it is acknowledged;
- `done_o` lasts one cycle, and `err_o` is never raised without it;
- a repeated clock finishes at once and quietly;
- a start during a run leaves the latched mode unchanged;
- no trim write and no lock read happen in legacy mode.

Other behaviour can only be shown by the bench scenarios, which compare every transfer against a queue the bench computes for itself. These are the exact order and values of the transfers for each mode, the drive-strength merge based on the PHY's current pad value, the frequency code, and the timeout against a PHY that never locks.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;

  localparam logic [7:0] A_DLL_STAT = 8'h00;
  localparam logic [7:0] A_PAD_CTL  = 8'h01;
  localparam logic [7:0] A_ITAP     = 8'h0C;
  localparam logic [7:0] A_OTAP     = 8'h0D;
  localparam logic [7:0] A_MODE     = 8'h11;
  localparam logic [7:0] A_TRIM     = 8'h12;

  typedef enum logic [2:0] {
    TM_LEGACY  = 3'd0,
    TM_HISPEED = 3'd1,
    TM_HS200   = 3'd2,
    TM_DDR50   = 3'd3,
    TM_HS400   = 3'd4,
    TM_STROBE  = 3'd5
  } tmode_e;

  typedef enum logic [3:0] {
    ST_MODE    = 4'd0,
    ST_PAD_RD  = 4'd1,
    ST_PAD_WR  = 4'd2,
    ST_OTAP    = 4'd3,
    ST_ITAP    = 4'd4,
    ST_TRIM    = 4'd5,
    ST_DLL_OFF = 4'd6,
    ST_DLL_ON  = 4'd7,
    ST_POLL    = 4'd8
  } step_e;

  function automatic tmode_e decode_mode(input logic strobe, input logic [2:0] m);
    if (strobe) return TM_STROBE;
    if (m > 3'd4) return TM_LEGACY;
    return tmode_e'(m);
  endfunction

  function automatic logic [1:0] freq_code(input logic [1:0] sel);
    case (sel)
      2'd1:    return 2'd2;
      2'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] mode_word(input tmode_e m);
    case (m)
      TM_STROBE: return 8'h01;
      TM_HS400:  return 8'h02;
      TM_LEGACY: return 8'h04;
      TM_DDR50:  return 8'h08;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] tap_word(input logic [6:0] tap);
    return {tap, 1'b1};
  endfunction

  function automatic logic [7:0] otap_word(input tmode_e m);
    case (m)
      TM_LEGACY:  return 8'h00;
      TM_HISPEED: return tap_word(7'd3);
      TM_HS200:   return tap_word(7'd2);
      default:    return tap_word(7'd1);
    endcase
  endfunction

  function automatic logic [7:0] itap_word(input tmode_e m);
    case (m)
      TM_LEGACY, TM_HS200: return 8'h00;
      TM_HISPEED:          return tap_word(7'd2);
      TM_HS400:            return tap_word(7'd10);
      default:             return tap_word(7'd0);
    endcase
  endfunction

  function automatic logic [7:0] dll_on_word(input logic [1:0] fc);
    return {1'b0, fc, 5'b01000};
  endfunction

  function automatic logic [7:0] pad_merge(input logic [7:0] cur, input logic [1:0] drv);
    return cur | {4'b0000, drv, 2'b00};
  endfunction

  function automatic logic step_used(input step_e s, input tmode_e m);
    case (s)
      ST_PAD_RD, ST_PAD_WR:        return (m == TM_HS400) || (m == TM_HS200);
      ST_TRIM, ST_DLL_ON, ST_POLL: return m != TM_LEGACY;
      default:                     return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/phycfg_step_decode.sv
module phycfg_step_decode
  import phycfg_pkg::*;
#(
  parameter logic [7:0] DLL_TRIM = 8'h08
) (
  input  step_e      step_i,
  input  tmode_e     mode_i,
  input  logic [1:0] fcode_i,
  input  logic [1:0] drv_i,
  input  logic [7:0] pad_i,
  output logic       used_o,
  output logic       we_o,
  output logic [7:0] addr_o,
  output logic [7:0] wdata_o
);

  always_comb begin
    used_o  = step_used(step_i, mode_i);
    we_o    = 1'b1;
    addr_o  = A_DLL_STAT;
    wdata_o = 8'h00;
    case (step_i)
      ST_MODE: begin
        addr_o  = A_MODE;
        wdata_o = mode_word(mode_i);
      end
      ST_PAD_RD: begin
        we_o   = 1'b0;
        addr_o = A_PAD_CTL;
      end
      ST_PAD_WR: begin
        addr_o  = A_PAD_CTL;
        wdata_o = pad_merge(pad_i, drv_i);
      end
      ST_OTAP: begin
        addr_o  = A_OTAP;
        wdata_o = otap_word(mode_i);
      end
      ST_ITAP: begin
        addr_o  = A_ITAP;
        wdata_o = itap_word(mode_i);
      end
      ST_TRIM: begin
        addr_o  = A_TRIM;
        wdata_o = DLL_TRIM;
      end
      ST_DLL_ON: begin
        wdata_o = dll_on_word(fcode_i);
      end
      ST_POLL: begin
        we_o = 1'b0;
      end
      default: begin
        wdata_o = 8'h00;
      end
    endcase
  end

endmodule

// File: rtl/phycfg_port_master.sv
module phycfg_port_master #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  output logic          xfer_done_o
);

  assign xfer_done_o = req_o && ack_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (issue_i && !req_o) begin
      req_o   <= 1'b1;
      we_o    <= we_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end else if (xfer_done_o) begin
      req_o <= 1'b0;
    end
  end

endmodule

// File: rtl/phycfg_lock_timer.sv
module phycfg_lock_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q >= CW'(LIMIT));

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !run_i) begin
      cnt_q <= '0;
    end else if (!expired_o) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/phycfg_ctrl.sv
module phycfg_ctrl
  import phycfg_pkg::*;
#(
  parameter int         LOCK_TIMEOUT = 256,
  parameter logic [7:0] DLL_TRIM     = 8'h08,
  parameter int         LOCK_BIT     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] mode_i,
  input  logic       strobe_en_i,
  input  logic [1:0] freq_sel_i,
  input  logic [1:0] drv_i,
  output logic       done_o,
  output logic       err_o,
  output logic       phy_req_o,
  output logic       phy_we_o,
  output logic [7:0] phy_addr_o,
  output logic [7:0] phy_wdata_o,
  input  logic       phy_ack_i,
  input  logic [7:0] phy_rdata_i
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

  state_e     state_q;
  step_e      step_q;
  tmode_e     mode_q;
  logic [1:0] fcode_q;
  logic [1:0] drv_q;
  logic [7:0] pad_q;
  logic [1:0] last_sel_q;
  logic       last_vld_q;
  logic       fail_q;

  logic       used;
  logic       dec_we;
  logic [7:0] dec_addr;
  logic [7:0] dec_wdata;
  logic       xfer_done;
  logic       lock_expired;

  // named events, also used by the checker
  logic busy;
  logic skip_hit;
  logic start_taken;
  logic issue;
  logic polling;
  logic lock_seen;

  assign busy        = (state_q != S_IDLE);
  assign skip_hit    = (state_q == S_IDLE) && start_i && last_vld_q && (freq_sel_i == last_sel_q);
  assign start_taken = (state_q == S_IDLE) && start_i && !skip_hit;
  assign issue       = (state_q == S_RUN) && used && !phy_req_o;
  assign polling     = (state_q == S_RUN) && (step_q == ST_POLL);
  assign lock_seen   = phy_rdata_i[LOCK_BIT];

  assign done_o = (state_q == S_FIN);
  assign err_o  = (state_q == S_FIN) && fail_q;

  phycfg_step_decode #(.DLL_TRIM(DLL_TRIM)) dec_i (
    .step_i  (step_q),
    .mode_i  (mode_q),
    .fcode_i (fcode_q),
    .drv_i   (drv_q),
    .pad_i   (pad_q),
    .used_o  (used),
    .we_o    (dec_we),
    .addr_o  (dec_addr),
    .wdata_o (dec_wdata)
  );

  phycfg_port_master #(.AW(8), .DW(8)) port_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue),
    .we_i        (dec_we),
    .addr_i      (dec_addr),
    .wdata_i     (dec_wdata),
    .req_o       (phy_req_o),
    .we_o        (phy_we_o),
    .addr_o      (phy_addr_o),
    .wdata_o     (phy_wdata_o),
    .ack_i       (phy_ack_i),
    .xfer_done_o (xfer_done)
  );

  phycfg_lock_timer #(.LIMIT(LOCK_TIMEOUT)) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (polling),
    .expired_o (lock_expired)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      step_q     <= ST_MODE;
      mode_q     <= TM_LEGACY;
      fcode_q    <= 2'd0;
      drv_q      <= 2'd0;
      pad_q      <= 8'h00;
      last_sel_q <= 2'd0;
      last_vld_q <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (skip_hit) begin
            fail_q  <= 1'b0;
            state_q <= S_FIN;
          end else if (start_taken) begin
            mode_q     <= decode_mode(strobe_en_i, mode_i);
            fcode_q    <= freq_code(freq_sel_i);
            drv_q      <= drv_i;
            last_sel_q <= freq_sel_i;
            last_vld_q <= 1'b1;
            fail_q     <= 1'b0;
            step_q     <= ST_MODE;
            state_q    <= S_RUN;
          end
        end
        S_RUN: begin
          if (!used) begin
            if (step_q == ST_POLL) state_q <= S_FIN;
            else step_q <= step_e'(step_q + 4'd1);
          end else if (xfer_done) begin
            if (step_q == ST_POLL) begin
              if (lock_seen) begin
                state_q <= S_FIN;
              end else if (lock_expired) begin
                fail_q  <= 1'b1;
                state_q <= S_FIN;
              end
            end else begin
              if (step_q == ST_PAD_RD) pad_q <= phy_rdata_i;
              step_q <= step_e'(step_q + 4'd1);
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phycfg_ctrl_chk.sv
module phycfg_ctrl_chk
  import phycfg_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       done_o,
  input logic       err_o,
  input logic       phy_req_o,
  input logic       phy_we_o,
  input logic [7:0] phy_addr_o,
  input logic [7:0] phy_wdata_o,
  input logic       phy_ack_i,
  input logic       busy,
  input logic       skip_hit,
  input tmode_e     mode_q
);

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && !phy_ack_i |=> phy_req_o && $stable(phy_we_o) && $stable(phy_addr_o) && $stable(phy_wdata_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R2
  skip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_hit |=> done_o && !err_o && !phy_req_o);

  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && start_i |=> $stable(mode_q));

  // R6
  trim_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && phy_we_o && (phy_addr_o == A_TRIM) |-> mode_q != TM_LEGACY);

  // R7
  poll_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && !phy_we_o && (phy_addr_o == A_DLL_STAT) |-> mode_q != TM_LEGACY);

endmodule

bind phycfg_ctrl phycfg_ctrl_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .done_o      (done_o),
  .err_o       (err_o),
  .phy_req_o   (phy_req_o),
  .phy_we_o    (phy_we_o),
  .phy_addr_o  (phy_addr_o),
  .phy_wdata_o (phy_wdata_o),
  .phy_ack_i   (phy_ack_i),
  .busy        (busy),
  .skip_hit    (skip_hit),
  .mode_q      (mode_q)
);

// File: tb/phycfg_ctrl_tb_top.sv
module phycfg_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       strobe = 1'b0;
  logic [1:0] fsel = 2'd0;
  logic [1:0] drv = 2'd0;
  logic       done, err, req, we, ack;
  logic [7:0] addr, wdata, rdata;

  always #2 clk = ~clk;

  phycfg_ctrl #(.LOCK_TIMEOUT(40)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .strobe_en_i(strobe), .freq_sel_i(fsel), .drv_i(drv),
    .done_o(done), .err_o(err), .phy_req_o(req), .phy_we_o(we),
    .phy_addr_o(addr), .phy_wdata_o(wdata), .phy_ack_i(ack), .phy_rdata_i(rdata)
  );

  // PHY model: one-cycle acknowledge, pad register, DLL with lock delay
  logic [7:0] pad_reg = 8'h41;
  int lock_cnt = -1;
  int lock_delay = 12;
  logic ack_q = 1'b0;
  logic [7:0] rdata_q = 8'h00;
  assign ack = ack_q;
  assign rdata = rdata_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= 8'h00;
    end else begin
      ack_q <= req && !ack_q;
      if (lock_cnt > 0) lock_cnt <= lock_cnt - 1;
      if (req && !ack_q) begin
        if (we) begin
          if (addr == 8'h01) pad_reg <= wdata;
          if (addr == 8'h00) lock_cnt <= wdata[3] ? lock_delay : -1;
          rdata_q <= 8'h00;
        end else if (addr == 8'h01) rdata_q <= pad_reg;
        else if (addr == 8'h00 && lock_cnt == 0) rdata_q <= 8'h10;
        else rdata_q <= 8'h00;
      end
    end
  end

  // reference queue: {kind, addr, data}; kind 0 write, 1 read, 2 lock poll
  logic [17:0] expq[$];
  string tagq[$];
  int n_cmp = 0;
  int n_bad = 0;
  int cyc_all = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int a, input int d, input string tag);
    expq.push_back({2'(kind), 8'(a), 8'(d)});
    tagq.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && req) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R11", "transfer with none expected", {we, addr}, 0);
      end else begin
        logic [17:0] h;
        h = expq[0];
        if (h[17:16] == 2'd2) begin
          chk(!we && addr == 8'h00, "R7", "lock poll read", {we, addr}, 0);
        end else begin
          chk(we == (h[17:16] == 2'd0) && addr == h[15:8], tagq[0], "kind/addr",
              {we, addr}, {(h[17:16] == 2'd0), h[15:8]});
          if (h[17:16] == 2'd0) chk(wdata == h[7:0], tagq[0], "write data", wdata, h[7:0]);
        end
        if (ack && h[17:16] != 2'd2) begin
          void'(expq.pop_front());
          void'(tagq.pop_front());
        end
      end
    end
  end

  // behavioural expectation of one run; md 5 stands for enhanced strobe
  task automatic plan_run(input int md, input int fs, input int dv);
    int fc, mw, ot, it;
    bit leg;
    fc  = (fs == 1) ? 2 : (fs == 2) ? 1 : 0;
    leg = (md == 0);
    case (md)
      5: begin mw = 8'h01; ot = 1; it = 0;  end
      4: begin mw = 8'h02; ot = 1; it = 10; end
      3: begin mw = 8'h08; ot = 1; it = 0;  end
      2: begin mw = 8'h00; ot = 2; it = -1; end
      1: begin mw = 8'h00; ot = 3; it = 2;  end
      default: begin mw = 8'h04; ot = -1; it = -1; end
    endcase
    push(0, 8'h11, mw, "R3");
    if (md == 2 || md == 4) begin
      push(1, 8'h01, 0, "R4");
      push(0, 8'h01, int'(pad_reg) | (dv << 2), "R4");
    end
    push(0, 8'h0D, (ot < 0) ? 0 : ((ot << 1) | 1), "R5");
    push(0, 8'h0C, (it < 0) ? 0 : ((it << 1) | 1), "R5");
    if (!leg) push(0, 8'h12, 8'h08, "R6");
    push(0, 8'h00, 8'h00, "R7");
    if (!leg) begin
      push(0, 8'h00, (fc << 5) | 8, "R8");
      push(2, 0, 0, "R7");
    end
  endtask

  task automatic run(input int md, input bit enh, input int fs, input int dv,
                     input bit exp_skip, input bit exp_err, input bit poke);
    int cyc;
    if (!exp_skip) plan_run(enh ? 5 : md, fs, dv);
    @(negedge clk);
    mode = 3'(md); strobe = enh; fsel = 2'(fs); drv = 2'(dv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (exp_skip) begin
      chk(done && !err && !req, "R2", "repeated clock finishes at once", {done, err, req}, 3'b100);
      @(negedge clk);
      chk(!done && !req, "R2", "no activity after quick finish", {done, req}, 0);
      return;
    end
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 6) begin
        mode = 3'd0; strobe = 1'b0; fsel = 2'd0; start = 1'b1;
      end else if (poke && cyc == 7) begin
        start = 1'b0;
      end
    end
    chk(done, "R11", "run reached done", done, 1);
    chk(err == exp_err, exp_err ? "R9" : "R7", "error flag", err, exp_err);
    chk(expq.size() == 0 || (expq.size() == 1 && expq[0][17:16] == 2'd2),
        poke ? "R10" : "R7", "all expected transfers seen", expq.size(), 0);
    expq.delete();
    tagq.delete();
    @(negedge clk);
    chk(!done, "R11", "done lasts one cycle", done, 0);
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!done && !err && !req, "R1", "outputs after reset", {done, err, req}, 0);
    run(0, 0, 0, 0, 0, 0, 0);     // legacy, first run always executes (R2)
    run(0, 0, 0, 0, 1, 0, 0);     // same clock -> skipped (R2)
    run(1, 0, 1, 0, 0, 0, 0);     // high speed, 100 MHz code 2 (R8)
    run(2, 0, 2, 2, 0, 0, 0);     // HS200 with pad merge, code 1 (R4)
    run(4, 0, 3, 1, 0, 0, 0);     // HS400, other clock code 0 (R5)
    run(3, 0, 0, 0, 0, 0, 0);     // DDR50
    run(4, 1, 1, 3, 0, 0, 0);     // strobe overrides HS400 (R3)
    run(1, 0, 2, 0, 0, 0, 1);     // start during run ignored (R10)
    run(1, 0, 2, 0, 1, 0, 0);     // recorded clock kept -> skip (R10)
    lock_delay = 100000;
    run(3, 0, 1, 0, 0, 1, 0);     // lock timeout (R9)
    lock_delay = 12;
    run(2, 0, 0, 1, 0, 0, 0);     // recovery after error
    repeat (5) @(negedge clk);
    chk(!req && !done, "R9", "quiet after last run", {req, done}, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule